// File: doc/BRIEF.md
# Slow-Clock Watchdog Timer

This block is a software-programmed watchdog that counts on a 32.768 kHz slow clock. A prescaler divides the slow clock by 128, and each prescaler wrap decrements a 16-bit counter. When the counter runs out, the watchdog has overflowed. It then reloads from the configured value and keeps counting. Software stops this by issuing a restart command periodically.

An overflow can trigger three actions, each enabled separately. It always sets a sticky overflow flag, and that flag can be routed to an interrupt line. It can drive an active-low alarm pin for exactly eight slow-clock cycles. It can raise a one-cycle internal reset request. Configuration changes alone never disturb the running count. Only a restart command reloads it.

The registers sit in a fast bus-clock domain. Register writes reach the slow domain through a toggle request/acknowledge handshake. Overflow events return to the bus domain as a toggle.

Top module: `slow_wdt`

## Requirements
- R1: After reset the mode register reads 0x00020000, the status flag reads 0, irq is 0, alarm_n is 1 and reset_req is 0. The counter starts running with a reload of 0.
- R2: The registers are addressed as follows. Offset 0 is the mode register: bits 15:0 hold the reload value, bit 16 enables the reset request, bit 17 enables the alarm pin, bit 18 enables the interrupt, and bits 31:19 read 0. Offset 1 is the control register: bit 0 is restart and the register reads 0. Offset 2 is status: bit 0 is the overflow flag. Read data is registered and valid in the cycle after reg_rd.
- R3: Writing 1 to control bit 0 loads the reload value and clears the prescaler. The first overflow follows the load by reload×128 slow cycles.
- R4: The counter decrements once per 128 slow cycles. A reload of N gives an overflow period of N×128 slow cycles, and a reload of 0 counts as 65536.
- R5: Writing the mode register does not reload the counter. The period in progress ends on its old schedule, and the new reload value is used from the next reload on.
- R6: After each overflow the counter reloads and runs again, so successive overflows are spaced exactly N×128 slow cycles apart.
- R7: An overflow sets the status flag. A status read returns 1 and clears the flag, so the next read returns 0.
- R8: irq equals the status flag ANDed with mode bit 18.
- R9: When mode bit 17 is set, alarm_n goes low for exactly 8 slow cycles after each overflow. When the bit is clear, alarm_n stays high.
- R10: When mode bit 16 is set, reset_req is high for exactly one slow cycle per overflow. When the bit is clear, reset_req never rises.
- R11: Writes issued while a transfer is still in flight are merged into the next transfer and are not lost. A restart carries the newest mode value written before it crosses.
- R12: Writing the control register with bit 0 clear has no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register interface clock |
| bus_rst_n | input | 1 | Synchronous active-low reset, bus domain |
| slow_clk | input | 1 | Slow counting clock |
| slow_rst_n | input | 1 | Synchronous active-low reset, slow domain |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| irq | output | 1 | Overflow interrupt |
| alarm_n | output | 1 | Active-low overflow pulse |
| reset_req | output | 1 | One-cycle reset request |

## Verification
The bench measures overflow spacing in slow cycles from the alarm and reset outputs. A prescaler off by one, or a counter that reloads one short, shows up as a wrong gap. A mode write that restarts the count by mistake shows up as a shortened period right after that write. The bench also issues mode, restart and mode writes on back-to-back bus cycles. A handshake that drops a write while busy would then lose the restart or use a stale reload. Pulse width is checked to exactly 8 cycles, the reset request to exactly one cycle, and disabled actions are checked to stay quiet through several overflows.

// File: rtl/slow_wdt_pkg.sv
// Shared constants and types for the slow-clock watchdog.
// Assumes a fixed 16-bit reload field at the bottom of the mode word.
package slow_wdt_pkg;
    localparam int REG_W      = 32;
    localparam int ADDR_W     = 2;
    localparam int CNT_W      = 16;
    localparam int RSTEN_BIT  = CNT_W;
    localparam int ALMEN_BIT  = CNT_W + 1;
    localparam int IRQEN_BIT  = CNT_W + 2;
    localparam int MODE_W     = CNT_W + 3;

    localparam logic [ADDR_W-1:0] ADDR_MODE = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;

    localparam logic [MODE_W-1:0] MODE_RESET = MODE_W'(32'h0002_0000);

    // Payload carried from the bus domain into the slow domain.
    typedef struct packed {
        logic             restart;
        logic             alm_en;
        logic             rst_en;
        logic [CNT_W-1:0] reload;
    } xfer_t;

    // Build a payload from a mode word and a restart flag.
    function automatic xfer_t mode_to_xfer(input logic [MODE_W-1:0] m, input logic rs);
        xfer_t x;
        x.restart = rs;
        x.alm_en  = m[ALMEN_BIT];
        x.rst_en  = m[RSTEN_BIT];
        x.reload  = m[CNT_W-1:0];
        return x;
    endfunction
endpackage

// File: rtl/wdt_sync.sv
// Multi-stage flop synchronizer for single-bit level or toggle signals.
// Assumes the input is a quasi-static level; one clock of latency per stage.
module wdt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous input through the chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/wdt_bus_regs.sv
// Bus-domain register file: mode register, restart command, sticky overflow flag.
// Launches payloads to the slow domain with a toggle request. Writes arriving
// while a request is outstanding are merged and sent once the acknowledge returns.
module wdt_bus_regs
    import slow_wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic              irq,
    input  logic              ack_s,
    input  logic              ovf_tgl_s,
    output logic              req_tgl,
    output xfer_t             payload
);
    logic [MODE_W-1:0] mode_q;
    logic              pend_q, pend_rs_q, req_q, ovf_seen_q, flag_q;
    xfer_t             hold_q;

    wire mode_wr    = wr && (addr == ADDR_MODE);
    wire restart_wr = wr && (addr == ADDR_CTRL) && wdata[0];
    wire stat_rd    = rd && (addr == ADDR_STAT);
    wire busy       = (req_q != ack_s);
    wire launch     = pend_q && !busy;
    wire ovf_set    = (ovf_tgl_s != ovf_seen_q);
    wire unused_wdata = ^wdata[REG_W-1:MODE_W];

    // Hold the programmed mode word.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= MODE_RESET;
        else if (mode_wr) mode_q <= wdata[MODE_W-1:0];
    end

    // Track pending work; new writes override a launch in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q    <= 1'b0;
            pend_rs_q <= 1'b0;
        end else begin
            if (launch) begin
                pend_q    <= 1'b0;
                pend_rs_q <= 1'b0;
            end
            if (mode_wr) pend_q <= 1'b1;
            if (restart_wr) begin
                pend_q    <= 1'b1;
                pend_rs_q <= 1'b1;
            end
        end
    end

    // Capture the payload and toggle the request when the channel is free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= mode_to_xfer(MODE_RESET, 1'b0);
            req_q  <= 1'b0;
        end else if (launch) begin
            hold_q <= mode_to_xfer(mode_q, pend_rs_q);
            req_q  <= ~req_q;
        end
    end

    // Sticky overflow flag: set by a returning toggle edge, cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_seen_q <= 1'b0;
            flag_q     <= 1'b0;
        end else begin
            ovf_seen_q <= ovf_tgl_s;
            if (ovf_set)      flag_q <= 1'b1;
            else if (stat_rd) flag_q <= 1'b0;
        end
    end

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else if (rd) begin
            case (addr)
                ADDR_MODE: rdata <= {{(REG_W-MODE_W){1'b0}}, mode_q};
                ADDR_STAT: rdata <= {{(REG_W-1){1'b0}}, flag_q};
                default:   rdata <= '0;
            endcase
        end
    end

    assign irq     = flag_q & mode_q[IRQEN_BIT];
    assign req_tgl = req_q;
    assign payload = hold_q;

    // R11
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(hold_q));
    // R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !ovf_set) |=> !flag_q);
    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_set |=> flag_q);
endmodule

// File: rtl/wdt_core.sv
// Slow-domain watchdog engine: prescaler, 16-bit down counter, overflow actions.
// Assumes the payload is stable whenever the synchronized request differs from
// the last accepted one. Reload 0 wraps to count 65536 ticks.
module wdt_core
    import slow_wdt_pkg::*;
#(
    parameter int PRESCALE  = 128,
    parameter int PULSE_LEN = 8
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  req_s,
    input  xfer_t payload,
    output logic  ack,
    output logic  ovf_tgl,
    output logic  alarm_n,
    output logic  reset_req
);
    localparam int PRE_W = $clog2(PRESCALE);
    localparam int PL_W  = $clog2(PULSE_LEN);

    logic             seen_q, sh_alm_q, sh_rst_q, ovf_tgl_q, alarm_q, rreq_q;
    logic [CNT_W-1:0] sh_reload_q, cnt_q;
    logic [PRE_W-1:0] pre_q;
    logic [PL_W-1:0]  left_q;

    wire              new_x     = (req_s != seen_q);
    wire              tick      = (pre_q == PRE_W'(PRESCALE - 1));
    wire              ovf_ev    = tick && (cnt_q == CNT_W'(1));
    wire [CNT_W-1:0]  reload_nx = new_x ? payload.reload : sh_reload_q;
    wire              alm_nx    = new_x ? payload.alm_en : sh_alm_q;
    wire              rst_nx    = new_x ? payload.rst_en : sh_rst_q;

    // Accept a new payload and keep the slow-domain copy of the mode fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q      <= 1'b0;
            sh_reload_q <= MODE_RESET[CNT_W-1:0];
            sh_alm_q    <= MODE_RESET[ALMEN_BIT];
            sh_rst_q    <= MODE_RESET[RSTEN_BIT];
        end else if (new_x) begin
            seen_q      <= req_s;
            sh_reload_q <= payload.reload;
            sh_alm_q    <= payload.alm_en;
            sh_rst_q    <= payload.rst_en;
        end
    end

    // Prescaler and down counter; a restart reloads both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            cnt_q <= MODE_RESET[CNT_W-1:0];
        end else if (new_x && payload.restart) begin
            pre_q <= '0;
            cnt_q <= payload.reload;
        end else if (tick) begin
            pre_q <= '0;
            cnt_q <= ovf_ev ? reload_nx : cnt_q - CNT_W'(1);
        end else begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end

    // Overflow actions: event toggle, timed alarm pulse, one-cycle reset request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_tgl_q <= 1'b0;
            alarm_q   <= 1'b0;
            left_q    <= '0;
            rreq_q    <= 1'b0;
        end else begin
            rreq_q <= ovf_ev && rst_nx;
            if (ovf_ev) ovf_tgl_q <= ~ovf_tgl_q;
            if (ovf_ev && alm_nx) begin
                alarm_q <= 1'b1;
                left_q  <= PL_W'(PULSE_LEN - 1);
            end else if (alarm_q) begin
                if (left_q == '0) alarm_q <= 1'b0;
                else              left_q  <= left_q - PL_W'(1);
            end
        end
    end

    assign ack       = seen_q;
    assign ovf_tgl   = ovf_tgl_q;
    assign alarm_n   = ~alarm_q;
    assign reset_req = rreq_q;

    // R9
    alarm_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_ev && alm_nx) |=> !alarm_n);
    // R10
    rreq_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req);
    // R10
    rreq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reset_req) |-> $past(ovf_ev));
    // R3
    restart_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (new_x && payload.restart) |=> (cnt_q == $past(payload.reload)));
    // R5
    mode_no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (new_x && !payload.restart && !tick) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/slow_wdt.sv
// Top level of the slow-clock watchdog: bus registers, slow engine and the
// synchronizers between them. Assumes the two clocks are unrelated.
module slow_wdt
    import slow_wdt_pkg::*;
#(
    parameter int PRESCALE    = 128,
    parameter int PULSE_LEN   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              bus_clk,
    input  logic              bus_rst_n,
    input  logic              slow_clk,
    input  logic              slow_rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq,
    output logic              alarm_n,
    output logic              reset_req
);
    logic  req_tgl, req_s, ack, ack_s, ovf_tgl, ovf_tgl_s;
    xfer_t payload;

    wdt_bus_regs u_regs (
        .clk(bus_clk), .rst_n(bus_rst_n), .wr(reg_wr), .rd(reg_rd),
        .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata), .irq(irq),
        .ack_s(ack_s), .ovf_tgl_s(ovf_tgl_s), .req_tgl(req_tgl), .payload(payload)
    );

    wdt_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk(slow_clk), .rst_n(slow_rst_n), .d(req_tgl), .q(req_s)
    );
    wdt_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(bus_clk), .rst_n(bus_rst_n), .d(ack), .q(ack_s)
    );
    wdt_sync #(.STAGES(SYNC_STAGES)) u_ovf_sync (
        .clk(bus_clk), .rst_n(bus_rst_n), .d(ovf_tgl), .q(ovf_tgl_s)
    );

    wdt_core #(.PRESCALE(PRESCALE), .PULSE_LEN(PULSE_LEN)) u_core (
        .clk(slow_clk), .rst_n(slow_rst_n), .req_s(req_s), .payload(payload),
        .ack(ack), .ovf_tgl(ovf_tgl), .alarm_n(alarm_n), .reset_req(reset_req)
    );
endmodule

// File: tb/slow_wdt_tb_top.sv
module slow_wdt_tb_top;
    logic        bus_clk = 1'b0, slow_clk = 1'b0;
    logic        bus_rst_n = 1'b0, slow_rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, alarm_n, reset_req;

    always #2  bus_clk  = ~bus_clk;
    always #11 slow_clk = ~slow_clk;

    slow_wdt dut_i (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .slow_clk(slow_clk),
        .slow_rst_n(slow_rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .alarm_n(alarm_n), .reset_req(reset_req)
    );

    int checks = 0, errors = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Slow-cycle counter and overflow/pulse monitor.
    int  scyc = 0;
    int  ov_n = 0, ext_falls = 0, rst_rises = 0;
    int  low_run = 0, pin_w = 0, rst_run = 0, rst_w = 0;
    int  ov_t [0:255];
    bit  mon_en = 0, prev_pin = 1, prev_rst = 0;

    always @(posedge slow_clk) scyc <= scyc + 1;

    always @(negedge slow_clk) begin
        if (mon_en) begin
            if ((!alarm_n && prev_pin) || (reset_req && !prev_rst)) begin
                ov_t[ov_n & 255] = scyc;
                ov_n = ov_n + 1;
            end
            if (!alarm_n && prev_pin) ext_falls = ext_falls + 1;
            if (reset_req && !prev_rst) rst_rises = rst_rises + 1;
            if (!alarm_n) low_run = low_run + 1;
            else if (!prev_pin) begin pin_w = low_run; low_run = 0; end
            if (reset_req) rst_run = rst_run + 1;
            else if (prev_rst) begin rst_w = rst_run; rst_run = 0; end
        end
        prev_pin = alarm_n;
        prev_rst = reset_req;
    end

    // Watchdog on the whole run.
    int bus_cyc = 0;
    always @(posedge bus_clk) begin
        bus_cyc <= bus_cyc + 1;
        if (bus_cyc == 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", bus_cyc, 0);
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge bus_clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge bus_clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge bus_clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge bus_clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic wait_ev(input int target);
        int n = 0;
        while (ov_n < target && n < 40000) begin
            @(negedge bus_clk);
            n++;
        end
        chk(ov_n >= target, "R6 overflow arrival", ov_n, target);
    endtask

    function automatic logic [31:0] mode_word(input logic [15:0] rl, input bit rs, input bit al, input bit ie);
        return {13'd0, ie, al, rs, rl};
    endfunction

    typedef struct packed {
        logic [15:0] reload;
        logic        rsten;
        logic        alen;
        logic        ien;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{16'd1, 1'b0, 1'b1, 1'b1},
        '{16'd2, 1'b1, 1'b0, 1'b0},
        '{16'd3, 1'b1, 1'b1, 1'b1},
        '{16'd2, 1'b1, 1'b1, 1'b0},
        '{16'd1, 1'b1, 1'b0, 1'b1}
    };

    initial begin
        logic [31:0] rd;
        vec_t        v;
        int          tw, b0, ef0, rr0, n;

        repeat (4) @(negedge slow_clk);
        @(negedge bus_clk);
        bus_rst_n = 1'b1; slow_rst_n = 1'b1;
        @(negedge slow_clk);
        mon_en = 1;

        // R1 reset state
        bus_read(2'd0, rd);
        chk(rd == 32'h0002_0000, "R1 mode reset", rd, 32'h0002_0000);
        bus_read(2'd2, rd);
        chk(rd == 32'd0, "R1 status reset", rd, 0);
        chk(irq == 1'b0 && alarm_n == 1'b1 && reset_req == 1'b0, "R1 outputs idle",
            {irq, alarm_n, reset_req}, 3'b010);

        // R4 reload 0 counts 65536 ticks: no overflow in 1000 slow cycles
        b0 = ov_n;
        repeat (1000) @(negedge slow_clk);
        chk(ov_n == b0, "R4 reload zero long period", ov_n - b0, 0);

        // R2 register map
        bus_write(2'd0, 32'hFFFF_FFFF);
        bus_read(2'd0, rd);
        chk(rd == 32'h0007_FFFF, "R2 mode mask", rd, 32'h0007_FFFF);
        bus_read(2'd1, rd);
        chk(rd == 32'd0, "R2 control reads zero", rd, 0);

        // Table of configurations, one loop
        for (int i = 0; i < 5; i++) begin
            v = VECS[i];
            bus_write(2'd0, mode_word(v.reload, v.rsten, v.alen, v.ien));
            b0 = ov_n; ef0 = ext_falls; rr0 = rst_rises;
            @(negedge bus_clk);
            tw = scyc;
            reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'd1;
            @(negedge bus_clk);
            reg_wr = 1'b0;
            wait_ev(b0 + 2);
            n = ov_t[b0 & 255] - tw;
            chk(n > v.reload * 128 && n <= v.reload * 128 + 12, "R3 first overflow after restart",
                n, v.reload * 128);
            n = ov_t[(b0 + 1) & 255] - ov_t[b0 & 255];
            chk(n == v.reload * 128, "R4 R6 overflow spacing", n, v.reload * 128);
            repeat (10) @(negedge slow_clk);
            if (v.alen) begin
                chk(ext_falls - ef0 == 2, "R9 alarm pulse count", ext_falls - ef0, 2);
                chk(pin_w == 8, "R9 alarm width", pin_w, 8);
            end else begin
                chk(ext_falls == ef0, "R9 alarm disabled", ext_falls - ef0, 0);
            end
            if (v.rsten) begin
                chk(rst_rises - rr0 == 2, "R10 reset request count", rst_rises - rr0, 2);
                chk(rst_w == 1, "R10 reset request width", rst_w, 1);
            end else begin
                chk(rst_rises == rr0, "R10 reset request disabled", rst_rises - rr0, 0);
            end
            chk(irq == v.ien, "R8 irq follows enable", irq, v.ien);
            bus_read(2'd2, rd);
            chk(rd == 32'd1, "R7 status set", rd, 1);
            bus_read(2'd2, rd);
            chk(rd == 32'd0, "R7 status cleared by read", rd, 0);
            chk(irq == 1'b0, "R8 irq drops after clear", irq, 0);
        end

        // R5 and R12: mode write and restart-bit-clear write leave the period alone
        bus_write(2'd0, mode_word(16'd3, 1'b0, 1'b1, 1'b0));
        b0 = ov_n;
        bus_write(2'd1, 32'd1);
        wait_ev(b0 + 1);
        bus_write(2'd0, mode_word(16'd1, 1'b0, 1'b1, 1'b0));
        bus_write(2'd1, 32'd0);
        wait_ev(b0 + 3);
        n = ov_t[(b0 + 1) & 255] - ov_t[b0 & 255];
        chk(n == 384, "R5 R12 period unchanged by writes", n, 384);
        n = ov_t[(b0 + 2) & 255] - ov_t[(b0 + 1) & 255];
        chk(n == 128, "R5 new reload used after overflow", n, 128);

        // R11: back-to-back writes while a transfer is in flight
        repeat (10) @(negedge slow_clk);
        b0 = ov_n;
        @(negedge bus_clk);
        tw = scyc;
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = mode_word(16'd5, 1'b0, 1'b1, 1'b0);
        @(negedge bus_clk);
        reg_addr = 2'd1; reg_wdata = 32'd1;
        @(negedge bus_clk);
        reg_addr = 2'd0; reg_wdata = mode_word(16'd2, 1'b0, 1'b1, 1'b0);
        @(negedge bus_clk);
        reg_wr = 1'b0;
        wait_ev(b0 + 2);
        n = ov_t[b0 & 255] - tw;
        chk(n > 256 && n <= 256 + 20, "R11 merged restart timing", n, 256);
        n = ov_t[(b0 + 1) & 255] - ov_t[b0 & 255];
        chk(n == 256, "R11 merged reload value", n, 256);

        // R9 R10 both actions disabled: outputs quiet, flag still set
        bus_write(2'd0, mode_word(16'd1, 1'b0, 1'b0, 1'b0));
        bus_write(2'd1, 32'd1);
        repeat (20) @(negedge slow_clk);
        bus_read(2'd2, rd);
        ef0 = ext_falls; rr0 = rst_rises;
        repeat (600) @(negedge slow_clk);
        chk(ext_falls == ef0 && alarm_n == 1'b1, "R9 alarm stays high", ext_falls - ef0, 0);
        chk(rst_rises == rr0, "R10 no reset request", rst_rises - rr0, 0);
        bus_read(2'd2, rd);
        chk(rd == 32'd1, "R7 flag set with actions off", rd, 1);
        chk(irq == 1'b0, "R8 irq masked", irq, 0);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule